// File: doc/BRIEF.md
# Serial Memory Target Engine for a Two-Wire Bus

This block is the protocol side of a byte-addressed serial memory that answers on an I2C bus as a target. It works entirely in a fast system clock domain. SCL and SDA arrive already synchronised, and the block pulls SDA low through an output enable (open-drain style). It detects START, repeated START and STOP. It checks the select byte against its type code and three strap inputs, and acknowledges the select byte, both address bytes and each accepted data byte. It runs byte writes, page writes, immediate reads, selective reads and sequential reads against a 32,768 x 8 memory port.

A current-address pointer lives inside the block and keeps its value between transactions. Written bytes go out one at a time on a write strobe. A STOP that closes a write holding accepted data raises a one-cycle commit request to the write engine that sits behind the port. While that engine reports busy, the block refuses its select byte, so a host can poll for completion. Write protect is sampled once per write, just before the first data byte.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the target releases SDA (`sda_oe_o` = 0), and `mem_wr_o`, `mem_rd_o` and `commit_o` are all low.
- R2: A select byte is acknowledged only when bits 7..4 are 1010, bits 3..1 equal `cs_strap_i[2:0]` and `busy_i` is low. Bit 0 is R/W, with 1 meaning read. A select byte that does not match gets no acknowledge, and the target ignores the bus until the next START.
- R3: A write transaction acknowledges both address bytes. The first address byte sent carries address bits 15..8, and bit 15 is ignored. Each data byte is acknowledged and produces one `mem_wr_o` pulse at the pointer. Between data bytes the pointer's low 6 bits count up and wrap within the page, while bits 14..6 stay fixed.
- R4: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START at any point abandons a partly received byte and begins select-byte reception.
- R5: While `busy_i` is high at the end of the select byte, the select byte is not acknowledged, for reads and for writes alike.
- R6: `wp_i` is sampled on the SCL falling edge that ends the acknowledge of the second address byte. If it is high, the first data byte is not acknowledged, no `mem_wr_o` is issued and no commit follows.
- R7: A read select byte with no address phase returns data starting at the pointer, which is one past the last byte written or read.
- R8: When the master acknowledges a read byte, the next byte follows. The pointer steps through the whole memory and wraps from 0x7FFF to 0x0000.
- R9: A write select byte and two address bytes, followed by a repeated START and a read select byte, load the pointer and read from that address.
- R10: After a master NoACK the target keeps SDA released for every further SCL clock until the next START or STOP.
- R11: `commit_o` pulses once on a STOP that ends a write in which at least one data byte was accepted. It does not pulse after a read, after a write with address bytes only, or after a refused transaction.
- R12: Data bits go out most significant bit first, and `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cs_strap_i | input | 3 | Chip-select strap value compared with select bits 3..1 |
| wp_i | input | 1 | Write protect level |
| busy_i | input | 1 | Write engine is busy with an internal write cycle |
| mem_addr_o | output | ADDR_W | Memory byte address for read or write strobes |
| mem_rd_o | output | 1 | Read strobe. Data is expected on `mem_rdata_i` one cycle later |
| mem_rdata_i | input | 8 | Read data |
| mem_wr_o | output | 1 | Write strobe for one data byte |
| mem_wdata_o | output | 8 | Write data |
| commit_o | output | 1 | One-cycle request to start the internal write cycle |

## Verification
The hardest states to reach are the ones that hinge on a single SCL edge. One is write protect, which counts only at the falling edge that closes the second address acknowledge. The other is the repeated START, which arrives after the master has already raised SCL for what the target takes as the first bit of a data byte. The bench reaches these with a bit-level master model. It changes `wp_i` only across the second address byte, so the strobe edge is the only place it is high. It issues a repeated START straight after a dummy write and also after four bits of a select byte, so the partial byte has to be dropped. The pointer wrap is reached by selecting 0x7FFE and reading three bytes in sequence.

// File: rtl/i2cmt_pkg.sv
package i2cmt_pkg;
  localparam int BYTE_W = 8;
  localparam int CS_W   = 3;
  localparam logic [3:0] SEL_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_WAIT
  } eng_st_e;
endpackage

// File: rtl/i2cmt_bus_cond.sv
module i2cmt_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cmt_byte_shift.sv
module i2cmt_byte_shift #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_i,
  input  logic          rise,
  input  logic          fall,
  input  logic          ack_ph,
  input  logic          clr,
  input  logic          load,
  input  logic [BW-1:0] load_val,
  output logic [BW-1:0] rx_byte,
  output logic          tx_msb,
  output logic          full
);
  localparam int CW = $clog2(BW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(BW);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [BW-1:0] rx_q, rx_n, tx_q, tx_n;

  always_comb begin
    cnt_n = cnt_q;
    rx_n  = rx_q;
    tx_n  = tx_q;
    if (clr) begin
      cnt_n = '0;
    end else if (rise && !ack_ph && cnt_q != CNT_FULL) begin
      rx_n  = {rx_q[BW-2:0], sda_i};
      cnt_n = cnt_q + 1'b1;
    end
    if (load) begin
      tx_n = load_val;
    end else if (fall && !ack_ph && cnt_q != '0 && cnt_q != CNT_FULL) begin
      tx_n = {tx_q[BW-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '1;
    end else begin
      cnt_q <= cnt_n;
      rx_q  <= rx_n;
      tx_q  <= tx_n;
    end
  end

  assign rx_byte = rx_q;
  assign tx_msb  = tx_q[BW-1];
  assign full    = (cnt_q == CNT_FULL);

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/i2cmt_addr_ptr.sv
module i2cmt_addr_ptr #(
  parameter int AW = 15,
  parameter int PW = 6,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] byte_in,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic          step_page,
  input  logic          step_lin,
  output logic [AW-1:0] ptr
);
  localparam int HW = AW - BW;

  logic [HW-1:0] hi_q, hi_n;
  logic [AW-1:0] ptr_q, ptr_n;

  always_comb begin
    hi_n  = hi_q;
    ptr_n = ptr_q;
    if (ld_hi) begin
      hi_n = byte_in[HW-1:0];
    end
    if (ld_lo) begin
      ptr_n = {hi_q, byte_in};
    end else if (step_page) begin
      ptr_n = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + 1'b1};
    end else if (step_lin) begin
      ptr_n = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      ptr_q <= '0;
    end else begin
      hi_q  <= hi_n;
      ptr_q <= ptr_n;
    end
  end

  assign ptr = ptr_q;

  a_r3_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_page && !ld_lo) |=> ptr_q[AW-1:PW] == $past(ptr_q[AW-1:PW]));

  a_r8_lin_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_lin && !ld_lo && !step_page) |=> ptr_q == $past(ptr_q) + 1'b1);
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2cmt_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [CS_W-1:0]       cs_strap_i,
  input  logic                  wp_i,
  input  logic                  busy_i,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic                  mem_rd_o,
  input  logic [BYTE_W-1:0]     mem_rdata_i,
  output logic                  mem_wr_o,
  output logic [BYTE_W-1:0]     mem_wdata_o,
  output logic                  commit_o
);
  logic scl_q, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rx_byte;
  logic tx_msb, byte_full;
  logic [ADDR_W-1:0] ptr;

  eng_st_e st_q, st_n;
  logic ackph_q, ackph_n;
  logic drv_q, drv_n;
  logic mack_q, mack_n;
  logic wp_q, wp_n;
  logic hd_q, hd_n;
  logic rd_q, rd_n, wr_q, wr_n, cm_q, cm_n;
  logic rd_vld_q;
  logic [BYTE_W-1:0] rdbuf_q;
  logic [ADDR_W-1:0] maddr_q, maddr_n;
  logic [BYTE_W-1:0] wdat_q, wdat_n;
  logic sh_clr, sh_load, p_hi, p_lo, p_page, p_lin;
  logic sel_match, byte_end, ack_end;

  i2cmt_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cmt_byte_shift #(.BW(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .rise(scl_rise), .fall(scl_fall),
    .ack_ph(ackph_q), .clr(sh_clr), .load(sh_load), .load_val(rdbuf_q),
    .rx_byte(rx_byte), .tx_msb(tx_msb), .full(byte_full)
  );

  i2cmt_addr_ptr #(.AW(ADDR_W), .PW(PAGE_W), .BW(BYTE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .byte_in(rx_byte), .ld_hi(p_hi), .ld_lo(p_lo),
    .step_page(p_page), .step_lin(p_lin), .ptr(ptr)
  );

  assign sel_match = (rx_byte[7:4] == SEL_TYPE) && (rx_byte[3:1] == cs_strap_i);
  assign byte_end  = scl_fall && !ackph_q && byte_full;
  assign ack_end   = scl_fall && ackph_q;

  always_comb begin
    st_n    = st_q;
    ackph_n = ackph_q;
    drv_n   = drv_q;
    mack_n  = mack_q;
    wp_n    = wp_q;
    hd_n    = hd_q;
    rd_n    = 1'b0;
    wr_n    = 1'b0;
    cm_n    = 1'b0;
    maddr_n = maddr_q;
    wdat_n  = wdat_q;
    sh_clr  = 1'b0;
    sh_load = 1'b0;
    p_hi    = 1'b0;
    p_lo    = 1'b0;
    p_page  = 1'b0;
    p_lin   = 1'b0;
    if (start_det) begin
      st_n    = ST_SEL;
      ackph_n = 1'b0;
      drv_n   = 1'b0;
      hd_n    = 1'b0;
      sh_clr  = 1'b1;
    end else if (stop_det) begin
      st_n    = ST_IDLE;
      ackph_n = 1'b0;
      drv_n   = 1'b0;
      cm_n    = hd_q;
      hd_n    = 1'b0;
      sh_clr  = 1'b1;
    end else begin
      unique case (st_q)
        ST_SEL, ST_AHI, ST_ALO, ST_WDAT: begin
          if (byte_end) begin
            drv_n   = 1'b1;
            ackph_n = 1'b1;
            unique case (st_q)
              ST_SEL: begin
                if (!sel_match || busy_i) begin
                  st_n    = ST_WAIT;
                  drv_n   = 1'b0;
                  ackph_n = 1'b0;
                end else if (rx_byte[0]) begin
                  rd_n    = 1'b1;
                  maddr_n = ptr;
                end
              end
              ST_AHI: p_hi = 1'b1;
              ST_ALO: p_lo = 1'b1;
              default: begin
                if (wp_q) begin
                  st_n    = ST_WAIT;
                  drv_n   = 1'b0;
                  ackph_n = 1'b0;
                end else begin
                  wr_n    = 1'b1;
                  maddr_n = ptr;
                  wdat_n  = rx_byte;
                  p_page  = 1'b1;
                  hd_n    = 1'b1;
                end
              end
            endcase
          end else if (ack_end) begin
            drv_n   = 1'b0;
            ackph_n = 1'b0;
            sh_clr  = 1'b1;
            unique case (st_q)
              ST_SEL: begin
                st_n    = rx_byte[0] ? ST_RDAT : ST_AHI;
                sh_load = rx_byte[0];
              end
              ST_AHI: st_n = ST_ALO;
              ST_ALO: begin
                st_n = ST_WDAT;
                wp_n = wp_i;
              end
              default: ;
            endcase
          end
        end
        ST_RDAT: begin
          if (byte_end) begin
            ackph_n = 1'b1;
            p_lin   = 1'b1;
            rd_n    = 1'b1;
            maddr_n = ptr + 1'b1;
          end else if (ackph_q && scl_rise) begin
            mack_n = ~sda_i;
          end else if (ack_end) begin
            ackph_n = 1'b0;
            sh_clr  = 1'b1;
            if (mack_q) begin
              sh_load = 1'b1;
            end else begin
              st_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ackph_q  <= 1'b0;
      drv_q    <= 1'b0;
      mack_q   <= 1'b0;
      wp_q     <= 1'b0;
      hd_q     <= 1'b0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      cm_q     <= 1'b0;
      maddr_q  <= '0;
      wdat_q   <= '0;
      rd_vld_q <= 1'b0;
      rdbuf_q  <= '1;
    end else begin
      st_q     <= st_n;
      ackph_q  <= ackph_n;
      drv_q    <= drv_n;
      mack_q   <= mack_n;
      wp_q     <= wp_n;
      hd_q     <= hd_n;
      rd_q     <= rd_n;
      wr_q     <= wr_n;
      cm_q     <= cm_n;
      maddr_q  <= maddr_n;
      wdat_q   <= wdat_n;
      rd_vld_q <= rd_q;
      if (rd_vld_q) begin
        rdbuf_q <= mem_rdata_i;
      end
    end
  end

  assign sda_oe_o    = drv_q | ((st_q == ST_RDAT) & ~ackph_q & ~tx_msb);
  assign mem_addr_o  = maddr_q;
  assign mem_rd_o    = rd_q;
  assign mem_wr_o    = wr_q;
  assign mem_wdata_o = wdat_q;
  assign commit_o    = cm_q;

  a_r5_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEL && byte_end && busy_i) |=> !sda_oe_o);

  a_r4_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe_o);

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_o, mem_wr_o, mem_rd_o}));

  a_r12_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && scl_q) |-> $stable(sda_oe_o));
endmodule

// File: tb/i2c_mem_target_tb_top.sv
module i2c_mem_target_tb_top;
  localparam int Q = 4;
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, CS, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, CS, 1'b1};

  logic clk, rst_n;
  logic m_scl, m_sda, sda_line, sda_oe;
  logic wp, busy;
  logic [14:0] mem_addr;
  logic mem_rd, mem_wr, commit;
  logic [7:0] mem_rdata, mem_wdata;

  int nchk, nfail, wn, ncommit, viol;
  logic [14:0] wlog_a [16];
  logic [7:0]  wlog_d [16];
  logic scl_prev, oe_prev;
  bit done;

  assign sda_line = m_sda & ~sda_oe;

  i2c_mem_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .cs_strap_i(CS), .wp_i(wp), .busy_i(busy), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .commit_o(commit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ 8'hC3;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= pat(mem_addr);
    if (mem_wr && wn < 16) begin
      wlog_a[wn] <= mem_addr;
      wlog_d[wn] <= mem_wdata;
    end
    if (mem_wr) wn <= wn + 1;
    if (commit) ncommit <= ncommit + 1;
    if (rst_n && m_scl && scl_prev && sda_oe !== oe_prev) viol <= viol + 1;
    scl_prev <= m_scl;
    oe_prev  <= sda_oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    s = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      b = {b[6:0], s};
    end
    clk_bit(~mack, s);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 strobes", int'({mem_wr, mem_rd, commit}), 0);
  endtask

  task automatic t_byte_write();
    logic a0, a1, a2, a3;
    int w0 = wn, c0 = ncommit;
    bus_start();
    wr_byte(SEL_W, a0); wr_byte(8'h81, a1); wr_byte(8'h23, a2); wr_byte(8'h3C, a3);
    bus_stop(); tick(4);
    chk("R2 select ack", int'(a0), 1);
    chk("R3 addr/data acks", int'({a1, a2, a3}), 3'b111);
    chk("R3 one write", wn - w0, 1);
    chk("R3 addr bit15 ignored", int'(wlog_a[w0]), 15'h0123);
    chk("R3 data", int'(wlog_d[w0]), 8'h3C);
    chk("R11 commit after write", ncommit - c0, 1);
  endtask

  task automatic t_page_wrap();
    logic a;
    logic [7:0] d;
    int w0 = wn;
    bus_start();
    wr_byte(SEL_W, a); wr_byte(8'h01, a); wr_byte(8'h3E, a);
    wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a);
    bus_stop(); tick(4);
    chk("R3 page count", wn - w0, 3);
    chk("R3 page addr0", int'(wlog_a[w0]), 15'h013E);
    chk("R3 page addr1", int'(wlog_a[w0+1]), 15'h013F);
    chk("R3 page wrap addr", int'(wlog_a[w0+2]), 15'h0100);
    chk("R3 page wrap data", int'(wlog_d[w0+2]), 8'h33);
    bus_start();
    wr_byte(SEL_R, a);
    rd_byte(1'b0, d);
    bus_stop(); tick(4);
    chk("R7 immediate read ack", int'(a), 1);
    chk("R7 immediate read after write", int'(d), int'(pat(15'h0101)));
  endtask

  task automatic t_mismatch();
    logic a0, a1;
    int w0 = wn, c0 = ncommit;
    bus_start();
    wr_byte({4'b1010, 3'b010, 1'b0}, a0);
    wr_byte(8'h00, a1);
    wr_byte(8'h10, a1);
    bus_stop(); tick(4);
    chk("R2 strap mismatch nack", int'(a0), 0);
    chk("R2 ignored after mismatch", int'(a1), 0);
    chk("R2 no write", wn - w0, 0);
    bus_start();
    wr_byte({4'b0110, CS, 1'b0}, a0);
    bus_stop(); tick(4);
    chk("R2 type mismatch nack", int'(a0), 0);
    chk("R11 no commit refused", ncommit - c0, 0);
  endtask

  task automatic t_busy();
    logic a0, a1;
    busy = 1'b1;
    bus_start(); wr_byte(SEL_W, a0); bus_stop();
    bus_start(); wr_byte(SEL_R, a1); bus_stop();
    busy = 1'b0; tick(4);
    chk("R5 busy write nack", int'(a0), 0);
    chk("R5 busy read nack", int'(a1), 0);
    bus_start(); wr_byte(SEL_W, a0); bus_stop(); tick(4);
    chk("R5 ack after busy", int'(a0), 1);
  endtask

  task automatic t_wp();
    logic a, ad;
    int w0 = wn, c0 = ncommit;
    bus_start();
    wr_byte(SEL_W, a); wr_byte(8'h02, a);
    wp = 1'b1;
    wr_byte(8'h00, a);
    wp = 1'b0;
    wr_byte(8'h99, ad);
    bus_stop(); tick(4);
    chk("R6 data nack", int'(ad), 0);
    chk("R6 no write", wn - w0, 0);
    chk("R6 no commit", ncommit - c0, 0);
    chk("R11 addr-only write no commit", ncommit - c0, 0);
  endtask

  task automatic t_abort();
    logic a, s;
    int w0 = wn;
    bus_start();
    for (int i = 7; i >= 4; i--) clk_bit(SEL_W[i], s);
    bus_start();
    wr_byte(SEL_W, a);
    chk("R4 ack after aborted byte", int'(a), 1);
    wr_byte(8'h00, a); wr_byte(8'h40, a); wr_byte(8'h77, a);
    bus_stop(); tick(4);
    chk("R4 write after abort", int'(wlog_a[w0]), 15'h0040);
    chk("R4 data after abort", int'(wlog_d[w0]), 8'h77);
  endtask

  task automatic t_selective();
    logic a, s;
    logic [7:0] d0, d1, d2;
    int c0 = ncommit, rel = 0;
    bus_start();
    wr_byte(SEL_W, a); wr_byte(8'h7F, a); wr_byte(8'hFE, a);
    bus_start();
    wr_byte(SEL_R, a);
    chk("R9 read select ack", int'(a), 1);
    rd_byte(1'b1, d0); rd_byte(1'b1, d1); rd_byte(1'b0, d2);
    chk("R9 selective first", int'(d0), int'(pat(15'h7FFE)));
    chk("R8 sequential next", int'(d1), int'(pat(15'h7FFF)));
    chk("R8 wrap to zero", int'(d2), int'(pat(15'h0000)));
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      if (s) rel++;
    end
    chk("R10 released after NoACK", rel, 9);
    bus_stop(); tick(4);
    chk("R11 no commit after read", ncommit - c0, 0);
    bus_start();
    wr_byte(SEL_R, a);
    rd_byte(1'b0, d0);
    bus_stop(); tick(4);
    chk("R7 pointer after read", int'(d0), int'(pat(15'h0001)));
  endtask

  initial begin
    nchk = 0; nfail = 0; wn = 0; ncommit = 0; viol = 0; done = 0;
    m_scl = 1'b1; m_sda = 1'b1; wp = 1'b0; busy = 1'b0; mem_rdata = '0;
    rst_n = 1'b0;
    tick(5);
    t_reset();
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_mismatch();
    t_busy();
    t_wp();
    t_abort();
    t_selective();
    chk("R12 oe change while SCL high", viol, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule